// File: doc/BRIEF.md
# Double-Buffered Packed Grayscale Store

This block keeps the 12-bit brightness values for a chain of LED PWM driver devices, each with a parameterized number of channels (16 by default). Two copies of every channel value are held. One is live and is read out by the serial shifter. The other is a working copy that the host changes one channel at a time. The host presents a channel index and a value. The first accepted write after the copies have exchanged roles also refreshes the whole working copy from the live copy. This keeps channels the host did not touch at their current values.

At every PWM cycle boundary the sequencer pulses a swap request. If the working copy holds changes, the two copies exchange roles. If no changes are waiting, a pending forced resend still makes the sequencer transmit the unchanged live data. One cycle after each request the block returns a one-cycle flag that tells the sequencer whether to shift data in this cycle. The sequencer reads the live copy as a byte stream in wire order. The stream runs from the highest channel down to channel 0, and each pair of channels packs into three bytes.

Top module: `gs_frame_store`

## Requirements
- R1: After reset every live byte reads 0, send_gs is 0, no change is pending and a forced resend is armed, so the first swap request returns send_gs = 1.
- R2: With N = DEVICES*CH_PER_DEV channels, the live copy reads as N*3/2 bytes. Byte 3g holds bits 11:4 of channel N-1-2g. Byte 3g+1 holds bits 3:0 of that channel in bits 7:4 and bits 11:8 of channel N-2-2g in bits 3:0. Byte 3g+2 holds bits 7:0 of channel N-2-2g.
- R3: A write with wr_idx of N or more changes neither copy and creates no pending change.
- R4: An accepted write changes only the working copy. The live bytes do not move until a later swap, and the write marks a change as pending.
- R5: The first accepted write while nothing is pending first copies every live channel into the working copy. After the next swap, all channels other than the written one read their previous live values.
- R6: A swap request while a change is pending makes the working contents live and returns send_gs = 1. It also clears the pending mark, so a following swap with no writes and no forced resend returns send_gs = 0.
- R7: A pulse on force_req arms a forced resend. A swap request with nothing pending and a forced resend armed returns send_gs = 1 with the live data unchanged and disarms it. A swap that exchanges pending data leaves an armed resend armed.
- R8: A write accepted in the same cycle as a swap request is not lost and is not made live by that swap. It is placed in the new working copy, seeded from the new live contents, and becomes live at the next swap.
- R9: send_gs is 1 only in the cycle right after a swap request, and only when that request found a change pending or a forced resend armed.
- R10: A byte address of N*3/2 or more reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host write strobe for one channel value |
| wr_idx | input | IDX_W ($clog2(N)+1) | Channel index of the write |
| wr_val | input | 12 | Brightness value of the write |
| force_req | input | 1 | Arms a resend of the live data at the next clean swap |
| swap_req | input | 1 | Cycle-boundary pulse from the sequencer |
| send_gs | output | 1 | One-cycle answer to a swap request: shift data this cycle |
| rd_addr | input | BYTE_W ($clog2(N*3/2)+1) | Byte address into the packed live stream |
| rd_byte | output | 8 | Packed live byte at rd_addr, combinational |

## Verification
The assertions assume that swap_req is low while reset is held and in the first cycle after reset. They also assume that rd_addr only changes while no write or swap is in flight, so the live bytes do not move while the addresses are swept. The bench drives every input just after a falling edge and clears the strobes after one clock. It keeps swap_req low during reset. It sweeps the whole byte range only in idle cycles, and every channel write is a single one-cycle strobe. The whole channel range is written under several value patterns, including all-ones and all-zeros. Every byte is compared against packing computed in the bench from a model of both copies.

// File: rtl/gs_pkg.sv
package gs_pkg;
  localparam int GS_W = 12;
  typedef logic [GS_W-1:0] gs_word_t;
  typedef enum logic [1:0] {SLOT_HI = 2'd0, SLOT_MID = 2'd1, SLOT_LO = 2'd2} gs_slot_e;

  // Packs one byte of a channel pair: hi is the higher-numbered channel.
  function automatic logic [7:0] gs_slot_byte(gs_word_t hi, gs_word_t lo, gs_slot_e slot);
    logic [7:0] b;
    case (slot)
      SLOT_HI:  b = hi[11:4];
      SLOT_MID: b = {hi[3:0], lo[11:8]};
      SLOT_LO:  b = lo[7:0];
      default:  b = 8'h00;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/gs_rst_sync.sv
module gs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_n_out = s1_q;
endmodule

// File: rtl/gs_swap_ctrl.sv
module gs_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok,
  input  logic force_req,
  input  logic swap_req,
  output logic live_sel,
  output logic live_sel_nxt,
  output logic seed,
  output logic send_gs
);
  logic dirty_q, dirty_d;
  logic force_q, force_d;
  logic sel_q, sel_d;
  logic send_q, send_d;
  logic flip;

  always_comb begin
    flip    = swap_req & dirty_q;
    sel_d   = sel_q ^ flip;
    // seed the working copy when nothing is pending, or when roles exchange now
    seed    = ~dirty_q | flip;
    dirty_d = wr_ok ? 1'b1 : (flip ? 1'b0 : dirty_q);
    force_d = force_req | (force_q & ~(swap_req & ~dirty_q));
    send_d  = swap_req & (dirty_q | force_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
      force_q <= 1'b1;
      sel_q   <= 1'b0;
      send_q  <= 1'b0;
    end else begin
      dirty_q <= dirty_d;
      force_q <= force_d;
      sel_q   <= sel_d;
      send_q  <= send_d;
    end
  end

  assign live_sel     = sel_q;
  assign live_sel_nxt = sel_d;
  assign send_gs      = send_q;

  a_r4_write_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> dirty_q);
  a_r6_dirty_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && dirty_q && !wr_ok) |=> !dirty_q);
  a_r6_roles_exchange: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && dirty_q) |=> (sel_q != $past(sel_q)));
  a_r7_force_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && !dirty_q && force_q && !force_req) |=> !force_q);
  a_r7_force_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_req && dirty_q && force_q) |=> force_q);
  a_r9_send_origin: assert property (@(posedge clk) disable iff (!rst_n)
    send_gs |-> $past(swap_req));
endmodule

// File: rtl/gs_bank_pair.sv
module gs_bank_pair #(
  parameter int NCH   = 32,
  parameter int IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ok,
  input  logic [IDX_W-1:0]   wr_idx,
  input  gs_pkg::gs_word_t   wr_val,
  input  logic               seed,
  input  logic               live_sel,
  input  logic               live_sel_nxt,
  output gs_pkg::gs_word_t   live_words [NCH],
  output logic [NCH*gs_pkg::GS_W-1:0] live_flat
);
  import gs_pkg::*;

  gs_word_t word_q [2][NCH];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic     en;
      gs_word_t nxt;
      gs_word_t q;

      always_comb begin
        // only the copy that is the working one after this edge takes writes
        en = wr_ok & (live_sel_nxt != 1'(b));
        if (wr_idx == IDX_W'(i))
          nxt = wr_val;
        else if (seed)
          nxt = word_q[1-b][i];
        else
          nxt = word_q[b][i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (en)
          q <= nxt;
      end

      assign word_q[b][i] = q;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_live
    assign live_words[i] = live_sel ? word_q[1][i] : word_q[0][i];
    assign live_flat[i*GS_W +: GS_W] = live_words[i];
  end
endmodule

// File: rtl/gs_byte_packer.sv
module gs_byte_packer #(
  parameter int NCH    = 32,
  parameter int BYTE_W = 7
) (
  input  gs_pkg::gs_word_t live_words [NCH],
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [7:0]        rd_byte
);
  import gs_pkg::*;

  localparam int NBYTES = NCH * 3 / 2;
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

  int       addr_i, group_i, hi_i;
  gs_slot_e slot;
  gs_word_t hi_w, lo_w;

  always_comb begin
    addr_i  = int'(rd_addr);
    group_i = addr_i / 3;
    slot    = gs_slot_e'(2'(addr_i % 3));
    hi_i    = NCH - 1 - 2 * group_i;
    hi_w    = '0;
    lo_w    = '0;
    rd_byte = 8'h00;
    if (addr_i < NBYTES) begin
      hi_w    = live_words[CH_W'(hi_i)];
      lo_w    = live_words[CH_W'(hi_i - 1)];
      rd_byte = gs_slot_byte(hi_w, lo_w, slot);
    end
  end
endmodule

// File: rtl/gs_frame_store.sv
module gs_frame_store #(
  parameter int DEVICES    = 2,
  parameter int CH_PER_DEV = 16,
  localparam int NCH    = DEVICES * CH_PER_DEV,
  localparam int NBYTES = NCH * 3 / 2,
  localparam int IDX_W  = $clog2(NCH) + 1,
  localparam int BYTE_W = $clog2(NBYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [11:0]       wr_val,
  input  logic              force_req,
  input  logic              swap_req,
  output logic              send_gs,
  input  logic [BYTE_W-1:0] rd_addr,
  output logic [7:0]        rd_byte
);
  import gs_pkg::*;

  logic     core_rst_n;
  logic     wr_ok;
  logic     live_sel, live_sel_nxt, seed;
  gs_word_t live_words [NCH];
  logic [NCH*GS_W-1:0] live_flat;

  assign wr_ok = wr_en & (wr_idx < IDX_W'(NCH));

  gs_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  gs_swap_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .wr_ok        (wr_ok),
    .force_req    (force_req),
    .swap_req     (swap_req),
    .live_sel     (live_sel),
    .live_sel_nxt (live_sel_nxt),
    .seed         (seed),
    .send_gs      (send_gs)
  );

  gs_bank_pair #(.NCH(NCH), .IDX_W(IDX_W)) u_banks (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .wr_ok        (wr_ok),
    .wr_idx       (wr_idx),
    .wr_val       (wr_val),
    .seed         (seed),
    .live_sel     (live_sel),
    .live_sel_nxt (live_sel_nxt),
    .live_words   (live_words),
    .live_flat    (live_flat)
  );

  gs_byte_packer #(.NCH(NCH), .BYTE_W(BYTE_W)) u_pack (
    .live_words (live_words),
    .rd_addr    (rd_addr),
    .rd_byte    (rd_byte)
  );

  a_r3_oob_no_pending: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && wr_idx >= IDX_W'(NCH) && !swap_req) |=> $stable(live_sel));
  a_r4_live_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
    !swap_req |=> $stable(live_flat));
  a_r10_oob_read_zero: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_addr >= BYTE_W'(NBYTES)) |-> (rd_byte == 8'h00));
endmodule

// File: tb/gs_frame_store_tb.sv
module gs_frame_store_tb_top;
  localparam int NCH    = 32;
  localparam int NBYTES = 48;
  localparam int IDX_W  = 6;
  localparam int BYTE_W = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, force_req, swap_req;
  logic [IDX_W-1:0] wr_idx;
  logic [11:0] wr_val;
  logic [BYTE_W-1:0] rd_addr;
  logic send_gs;
  logic [7:0] rd_byte;

  int checks = 0;
  int fails  = 0;
  int mlive [NCH];
  int mwork [NCH];
  bit mdirty, mforce;

  always #10 clk = ~clk;

  gs_frame_store #(.DEVICES(2), .CH_PER_DEV(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .force_req(force_req), .swap_req(swap_req), .send_gs(send_gs),
    .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_byte(int b);
    int g, hi, lo;
    if (b >= NBYTES) return 0;
    g  = b / 3;
    hi = mlive[NCH - 1 - 2 * g];
    lo = mlive[NCH - 2 - 2 * g];
    case (b % 3)
      0:       return (hi >> 4) & 8'hFF;
      1:       return ((hi & 4'hF) << 4) | ((lo >> 8) & 4'hF);
      default: return lo & 8'hFF;
    endcase
  endfunction

  function automatic int pat(int i, int k);
    if (k == 0) return 12'hFFF;
    if (k == 1) return 0;
    return (i * 341 + k * 1123 + 7) & 12'hFFF;
  endfunction

  // one clock: drive after a falling edge, sample at the next falling edge
  task automatic cyc(bit we, int idx, int val, bit sw, bit fr, string req);
    bit ok, flip, exp_send;
    @(negedge clk);
    wr_en = we; wr_idx = IDX_W'(idx); wr_val = 12'(val);
    swap_req = sw; force_req = fr;
    ok       = we && (idx < NCH);
    exp_send = sw && (mdirty || mforce);
    flip     = sw && mdirty;
    if (flip) for (int i = 0; i < NCH; i++) mlive[i] = mwork[i];
    if (ok) begin
      if (!mdirty || flip) for (int i = 0; i < NCH; i++) mwork[i] = mlive[i];
      mwork[idx] = val;
    end
    mforce = fr || (mforce && !(sw && !mdirty));
    mdirty = ok ? 1'b1 : (flip ? 1'b0 : mdirty);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; swap_req = 1'b0; force_req = 1'b0;
    chk(req, int'(send_gs), int'(exp_send));
  endtask

  task automatic check_live(string req);
    for (int b = 0; b < NBYTES; b++) begin
      rd_addr = BYTE_W'(b);
      #1;
      chk(req, int'(rd_byte), exp_byte(b));
    end
  endtask

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_val = '0;
    force_req = 1'b0; swap_req = 1'b0; rd_addr = '0;
    for (int i = 0; i < NCH; i++) begin mlive[i] = 0; mwork[i] = 0; end
    mdirty = 1'b0; mforce = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 send_gs idle", int'(send_gs), 0);
    check_live("R1 live zero");
    cyc(0, 0, 0, 1, 0, "R1 first swap sends");
    cyc(0, 0, 0, 1, 0, "R9 clean swap silent");
    cyc(0, 0, 0, 0, 0, "R9 no swap no send");

    // R2/R4/R6: full writes under several patterns
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < NCH; i++) cyc(1, i, pat(i, k), 0, 0, "R4 write no send");
      check_live("R4 live held before swap");
      cyc(0, 0, 0, 1, 0, "R6 pending swap sends");
      check_live("R2 packed order");
      cyc(0, 0, 0, 1, 0, "R6 pending cleared");
    end

    // R5: single write seeds other channels from live
    cyc(1, 5, 12'hA5C, 0, 0, "R5 write");
    cyc(0, 0, 0, 1, 0, "R5 swap");
    check_live("R5 seeded copy");

    // R3: out-of-range indexes ignored
    for (int i = NCH; i < 64; i++) cyc(1, i, 12'h3C3, 0, 0, "R3 oob write");
    cyc(0, 0, 0, 1, 0, "R3 no pending after oob");
    check_live("R3 live unchanged");

    // R7: forced resend
    cyc(0, 0, 0, 0, 1, "R7 arm");
    cyc(0, 0, 0, 1, 0, "R7 forced send");
    check_live("R7 live unchanged");
    cyc(0, 0, 0, 1, 0, "R7 force consumed");
    cyc(1, 7, 12'h123, 0, 1, "R7 write and arm");
    cyc(0, 0, 0, 1, 0, "R7 dirty swap");
    cyc(0, 0, 0, 1, 0, "R7 force kept through dirty swap");
    cyc(0, 0, 0, 1, 0, "R7 then consumed");
    check_live("R7 data");

    // R8: write in a swap cycle while dirty
    cyc(1, 3, 12'hBEE, 0, 0, "R8 prior write");
    cyc(1, 9, 12'h9F1, 1, 0, "R8 swap with write");
    check_live("R8 write not yet live");
    cyc(0, 0, 0, 1, 0, "R8 write pending sends");
    check_live("R8 write now live");
    // R8: write in a swap cycle while clean
    cyc(1, 11, 12'h0E7, 1, 0, "R8 clean swap with write");
    check_live("R8 clean live unchanged");
    cyc(0, 0, 0, 1, 0, "R8 clean pending sends");
    check_live("R8 clean write live");

    // R10: out-of-range byte addresses
    for (int b = NBYTES; b < 128; b++) begin
      rd_addr = BYTE_W'(b);
      #1;
      chk("R10 oob read", int'(rd_byte), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule